// File: doc/BRIEF.md
# Windowed Capture Buffer Controller

This block records probed signals into an on-chip sample memory of fixed depth. A capture request arms it. In triggered mode the memory is split into a power-of-two number of equal windows. Each window starts filling on its own trigger event, so N windows hold N separate occurrences of the event. In immediate mode the whole memory fills at once, with no trigger needed.

Samples are taken only on cycles where the sample enable is high. The probe word is the concatenation of the monitored signals. By default this is 20 bits: a 12-bit sample with an 8-bit counter below it. When the last window is full, the block raises a done flag. From then on, a simple synchronous read port returns each stored entry with its window number and a marker that flags the trigger sample.

Top module: `capture_window_ctrl`

## Requirements
- R1: After reset, `ready_o`, `done_o` and `rd_valid_o` are all 0.
- R2: A request accepted with `imm_i`=0 raises `ready_o` from the next cycle. The window count is 2^`win_log2_i`, and values above log2(DEPTH) are clamped to log2(DEPTH), which gives windows of one entry.
- R3: An entry is written only in cycles where `sample_en_i` is 1. A trigger seen while `sample_en_i` is 0 does not start a window, and `ready_o` stays 1.
- R4: While armed, an enabled trigger sample is stored at offset 0 of the current window. The following enabled samples fill the rest of the window, which holds DEPTH/2^k entries. Triggers are ignored while a window is filling. When a window is full and it is not the last one, `ready_o` returns to 1 for the next window.
- R5: A request with `imm_i`=1 fills all DEPTH entries from consecutive enabled samples with no trigger, and `ready_o` stays 0.
- R6: `done_o` rises in the cycle after the last entry is written. It holds until the next request, and that request clears it in the following cycle.
- R7: Requests are ignored while a capture is armed or filling.
- R8: A read with `rd_en_i`=1 while `done_o`=1 returns the entry at `rd_addr_i` on `rd_data_o`, with `rd_valid_o`=1, one cycle later. A read while `done_o`=0 leaves `rd_valid_o` at 0.
- R9: `rd_win_o` equals `rd_addr_i` shifted right by log2(DEPTH)-k. In immediate mode it is 0.
- R10: `rd_trig_o` is 1 for offset 0 of each window in triggered mode and is always 0 in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | Sample qualifier |
| probe_i | input | PROBE_W | Concatenated probe word |
| trig_i | input | 1 | Trigger pulse from sequencer |
| cap_req_i | input | 1 | Capture request |
| imm_i | input | 1 | Immediate mode select, sampled with request |
| win_log2_i | input | LW | log2 of window count, sampled with request |
| ready_o | output | 1 | Armed, waiting for trigger |
| done_o | output | 1 | All windows full |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | PROBE_W | Stored probe word |
| rd_win_o | output | AW | Window number of the entry |
| rd_trig_o | output | 1 | Entry is the trigger sample |

## Verification
Captures are run with one window, eight windows, one-entry windows (the clamped count) and immediate mode. Together these separate the window-size arithmetic from the re-arm path and from the trigger-free fill. Sample enables and triggers are drawn at random densities:
- Sparse enables expose writes made on idle cycles.
- Dense triggers during filling expose a window restarting early.

Random probe words make every readback entry distinct, so an addressing or tag error shows up at a specific address. Requests issued mid-capture and reads issued before done check that both are ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FILL  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cap_sample_ram.sv
module cap_sample_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 20,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_en_i,
  input  logic          trig_i,
  input  logic          cap_req_i,
  input  logic          imm_i,
  input  logic [LW-1:0] win_log2_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          ready_o,
  output logic          done_o,
  output logic          imm_o,
  output logic [LW-1:0] wl_o
);
  cap_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic          done_q, imm_q;
  logic [LW-1:0] wl_q, wl_clamp;
  logic [AW-1:0] win_mask;
  logic          last_entry, win_end;

  assign wl_clamp   = (win_log2_i > LW'(AW)) ? LW'(AW) : win_log2_i;
  assign win_mask   = {AW{1'b1}} >> wl_q;
  assign last_entry = &ptr_q;
  assign win_end    = (ptr_q & win_mask) == win_mask;

  // trigger only opens a window on a qualified sample
  assign wr_en_o   = sample_en_i &&
                     ((state_q == ST_ARMED && trig_i) || state_q == ST_FILL);
  assign wr_addr_o = ptr_q;
  assign ready_o   = state_q == ST_ARMED;
  assign done_o    = done_q;
  assign imm_o     = imm_q;
  assign wl_o      = wl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      done_q  <= 1'b0;
      imm_q   <= 1'b0;
      wl_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cap_req_i) begin
            done_q  <= 1'b0;
            ptr_q   <= '0;
            imm_q   <= imm_i;
            wl_q    <= imm_i ? '0 : wl_clamp;
            state_q <= imm_i ? ST_FILL : ST_ARMED;
          end
        end
        ST_ARMED, ST_FILL: begin
          if (wr_en_o) begin
            if (last_entry) begin
              done_q  <= 1'b1;
              ptr_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= win_end ? ST_ARMED : ST_FILL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ARM_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cap_req_i && !imm_i) |=> ready_o); // R2
  AST_IMM_NEVER_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && imm_q) |-> !ready_o); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !cap_req_i) |=> done_q); // R6
  AST_REQ_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cap_req_i) |=> !done_q); // R6
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !wr_en_o) |=> ($stable(ptr_q) && $stable(wl_q))); // R7
  AST_READY_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o)); // R6
endmodule

// File: rtl/cap_read_tag.sv
module cap_read_tag #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(AW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          done_i,
  input  logic          imm_i,
  input  logic [LW-1:0] wl_i,
  output logic          ram_re_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_win_o,
  output logic          rd_trig_o
);
  logic [LW-1:0] shamt;
  logic [AW-1:0] offs_mask;

  assign ram_re_o  = rd_en_i && done_i;
  assign shamt     = LW'(AW) - wl_i;
  assign offs_mask = {AW{1'b1}} >> wl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_win_o   <= '0;
      rd_trig_o  <= 1'b0;
    end else begin
      rd_valid_o <= ram_re_o;
      if (ram_re_o) begin
        rd_win_o  <= rd_addr_i >> shamt;
        rd_trig_o <= !imm_i && ((rd_addr_i & offs_mask) == '0);
      end
    end
  end

  AST_NO_READ_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i) |=> !rd_valid_o); // R8
  AST_IMM_NO_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && imm_i && $stable(imm_i)) |-> !rd_trig_o); // R10
endmodule

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl #(
  parameter int DEPTH   = 1024,
  parameter int PROBE_W = 20,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = $clog2(AW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_en_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               trig_i,
  input  logic               cap_req_i,
  input  logic               imm_i,
  input  logic [LW-1:0]      win_log2_i,
  output logic               ready_o,
  output logic               done_o,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic               rd_valid_o,
  output logic [PROBE_W-1:0] rd_data_o,
  output logic [AW-1:0]      rd_win_o,
  output logic               rd_trig_o
);
  logic          wr_en, ram_re, imm_q;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] wl_q;

  cap_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(sample_en_i),
    .trig_i     (trig_i),
    .cap_req_i  (cap_req_i),
    .imm_i      (imm_i),
    .win_log2_i (win_log2_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .ready_o    (ready_o),
    .done_o     (done_o),
    .imm_o      (imm_q),
    .wl_o       (wl_q)
  );

  cap_sample_ram #(.DEPTH(DEPTH), .DW(PROBE_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(probe_i),
    .re_i   (ram_re),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  cap_read_tag #(.DEPTH(DEPTH)) u_tag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .done_i    (done_o),
    .imm_i     (imm_q),
    .wl_i      (wl_q),
    .ram_re_o  (ram_re),
    .rd_valid_o(rd_valid_o),
    .rd_win_o  (rd_win_o),
    .rd_trig_o (rd_trig_o)
  );

  AST_WR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sample_en_i); // R3
  AST_NO_WR_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_en); // R6
endmodule

// File: tb/capture_window_ctrl_test.sv
module capture_window_ctrl_test;
  localparam int DEPTH = 64;
  localparam int PW    = 20;
  localparam int AW    = 6;
  localparam int LW    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_en = 0, trig = 0, req = 0, imm = 0, rd_en = 0;
  logic [PW-1:0] probe = '0;
  logic [LW-1:0] wl = '0;
  logic [AW-1:0] rd_addr = '0;
  logic ready, done, rd_valid, rd_trig;
  logic [PW-1:0] rd_data;
  logic [AW-1:0] rd_win;

  int tests = 0, fails = 0, cycles = 0;

  // model state: 0 idle, 1 armed, 2 filling
  int m_state = 0, m_ptr = 0, m_wl = 0;
  bit m_done = 0, m_imm = 0, exp_rv = 0;
  logic [PW-1:0] exp_mem [DEPTH];

  capture_window_ctrl #(.DEPTH(DEPTH), .PROBE_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(sample_en), .probe_i(probe),
    .trig_i(trig), .cap_req_i(req), .imm_i(imm), .win_log2_i(wl),
    .ready_o(ready), .done_o(done), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_win_o(rd_win),
    .rd_trig_o(rd_trig));

  always #2 clk = ~clk;

  task automatic chk(string r, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int win_mask(int k);
    return (DEPTH - 1) >> k;
  endfunction

  task automatic model_step();
    exp_rv = rd_en && m_done;
    case (m_state)
      0: if (req) begin
        m_done = 0; m_ptr = 0; m_imm = imm;
        m_wl = imm ? 0 : ((int'(wl) > AW) ? AW : int'(wl));
        m_state = imm ? 2 : 1;
      end
      default: if (sample_en && (m_state == 2 || trig)) begin
        exp_mem[m_ptr] = probe;
        if (m_ptr == DEPTH - 1) begin
          m_done = 1; m_ptr = 0; m_state = 0;
        end else begin
          m_state = ((m_ptr & win_mask(m_wl)) == win_mask(m_wl)) ? 1 : 2;
          m_ptr++;
        end
      end
    endcase
  endtask

  // inputs set just after negedge; outputs compared at next negedge
  task automatic cyc(bit q, bit im, int k, bit en, bit tg, bit re, int ra);
    req = q; imm = im; wl = LW'(k); sample_en = en; trig = tg;
    rd_en = re; rd_addr = AW'(ra); probe = PW'($urandom);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R2/R4 ready_o", ready, m_state == 1);
    chk("R6 done_o", done, m_done);
    chk("R8 rd_valid_o", rd_valid, exp_rv);
  endtask

  task automatic capture(int k, bit im, int en_pct, int tg_pct);
    int guard = 0;
    cyc(1, im, k, 0, 0, 0, 0);
    while (!m_done && guard < 20000) begin
      bit en = ($urandom % 100) < en_pct;
      bit tg = ($urandom % 100) < tg_pct;
      bit q  = ($urandom % 16) == 0;   // R7: stray requests mid-capture
      bit re = ($urandom % 8) == 0;    // R8: reads before done
      cyc(q, ~im, $urandom % 8, en, tg, re, $urandom);
      guard++;
    end
    chk("R6 capture finished", m_done, 1);
  endtask

  task automatic readback(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      int ew = m_imm ? 0 : (a >> (AW - m_wl));
      bit et = !m_imm && ((a & win_mask(m_wl)) == 0);
      cyc(0, 0, 0, 0, 0, 1, a);
      chk({"R8 data ", tag}, rd_data, exp_mem[a]);
      chk({"R9 window ", tag}, rd_win, ew);
      chk({"R10 marker ", tag}, rd_trig, et);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk("R1 ready_o", ready, 0);
    chk("R1 done_o", done, 0);
    chk("R1 rd_valid_o", rd_valid, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 1, 0);

    // R3: trigger without enable must not open a window
    cyc(1, 0, 3, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R3 still armed", ready, 1);
    for (int i = 0; i < 4000 && !m_done; i++)
      cyc(0, 0, 0, ($urandom % 100) < 40, ($urandom % 100) < 30, 0, 0);
    readback("8win sparse");

    // R6: done persists through idle cycles
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 1, 0, 0);
    chk("R6 done held", done, 1);

    capture(3, 0, 90, 80);  readback("8win dense");   // R4
    capture(0, 0, 70, 10);  readback("1win");          // R4
    capture(6, 0, 60, 50);  readback("64win");         // R4
    capture(7, 0, 80, 50);  readback("clamped");       // R2
    chk("R2 clamp", m_wl, AW);
    capture(2, 1, 50, 90);  readback("imm");           // R5
    capture(4, 0, 100, 100); readback("16win full");

    // R6: request clears done next cycle
    cyc(1, 0, 1, 0, 0, 0, 0);
    chk("R6 done cleared", done, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule